// File: doc/BRIEF.md
# 8-bit CPU Effective Address Unit

This block resolves the operand of one instruction for an 8-bit processor core. A decoder hands it an addressing-mode code, the 16-bit operand field taken from the instruction stream, the X and Y index registers, the accumulator and an instruction-class code. On a `start` pulse it computes the effective address and fetches any indirect pointer and the operand byte through a synchronous byte-read port. It also reports the instruction length in bytes and the total cycle count the instruction would take.

Each read on the memory port is a one-cycle request. `mem_rdata` must hold the byte at `mem_addr` in the cycle after `mem_req` is high. The unit is built around a six-state machine:
- `S_IDLE` waits for `start`. From there it takes one of three routes: `S_PTR_LO` for the two pointer modes, `S_VAL_REQ` for the direct memory modes, or `S_DONE` for the modes that read nothing.
- `S_PTR_LO` requests the pointer low byte, then moves to `S_PTR_HI`.
- `S_PTR_HI` captures the low byte, requests the high byte, then moves to `S_VAL_REQ`.
- `S_VAL_REQ` forms the final address and requests the operand byte, then moves to `S_VAL_CAP`.
- `S_VAL_CAP` captures the operand byte, then moves to `S_DONE`.
- `S_DONE` raises `done` for one clock and returns to `S_IDLE`.

The results on the output ports stay stable from `done` until the next accepted `start`.

Top module: `ea_unit`

## Requirements
- R1: Mode codes are 0 immediate, 1 accumulator, 2 zero page, 3 zero page X, 4 zero page Y, 5 absolute, 6 absolute X, 7 absolute Y, 8 indexed indirect, 9 indirect indexed, 10 implied, 11 indirect absolute and 12 relative. In the zero page modes (2, 3, 4) the address is the low operand byte plus the index, if any, taken modulo 256, so the high address byte is always zero.
- R2: Absolute mode (5) uses the operand as the address. Modes 6 and 7 add X or Y to the operand modulo 65536.
- R3: Indexed indirect mode (8) reads the pointer low byte at page-zero address (operand low byte + X) mod 256 and the high byte at that address + 1, also mod 256. The pointer is the effective address.
- R4: Indirect indexed mode (9) reads the pointer low byte at the operand and the high byte at operand+1. The effective address is pointer + Y.
- R5: The operand value depends on the mode:
  - immediate: the low operand byte;
  - accumulator: `acc`;
  - memory modes: the byte read at the effective address.
  Modes 0, 1, 10, 11 and 12 issue no memory read and report effective address 0. Modes 10, 11 and 12 report value 0.
- R6: Length is 3 for modes 5, 6 and 7, 1 for mode 1, and 2 otherwise.
- R7: Base cycles for classes 0 and 1 (read/compare) depend on the mode:
  - immediate: 2;
  - zero page: 3;
  - zero page X, absolute, absolute X and absolute Y: 4;
  - indexed indirect: 6;
  - indirect indexed: 5.
  Any mode/class pair not listed in R7, R8 or R9 gives 2.
- R8: Base cycles for class 2 (read-modify-write) depend on the mode:
  - accumulator: 2;
  - zero page: 5;
  - zero page X and absolute: 6;
  - absolute X: 7.
- R9: Base cycles for class 3 (store accumulator) depend on the mode:
  - zero page: 3;
  - zero page X and absolute: 4;
  - absolute X and absolute Y: 5;
  - both indirect modes: 6.
- R10: Fixed cycle counts apply regardless of mode: class 4 takes 7, class 5 takes 6, class 6 takes 5, class 7 takes 4, class 8 takes 3, and any other class takes 2.
- R11: Only class 0 adds one cycle, and only in modes 6, 7 and 9, when the high byte of the indexed address differs from the high byte of the unindexed base.
- R12: `done` is high for exactly one clock. Measured from the clock edge that accepts `start`, `done` appears one clock later for non-reading modes with 0 reads, three clocks later for direct memory modes with 1 read, and five clocks later for the indirect modes with 3 reads.
- R13: `start` is ignored while `busy` is high; the running operation finishes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolution (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| operand | input | 16 | Operand field of the instruction |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc | input | 8 | Accumulator |
| iclass | input | 4 | Instruction-class code |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after a request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| eff_addr | output | 16 | Effective address |
| value | output | 8 | Operand value |
| length | output | 2 | Instruction length in bytes |
| cycles | output | 4 | Total cycle count |

## Verification
A wrong state transition shows up first in the timing of `done`: a skipped or repeated state moves the strobe away from 1, 3 or 5 clocks after `start`, and it changes the number of memory requests counted in the same window. A wrong captured pointer byte leaves the state sequence intact, so it appears only at `done`, as a wrong `eff_addr` and, through the operand read, a wrong `value`. A missed page-crossing penalty changes nothing until `cycles` is sampled at `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        M_IMM    = 4'd0,
        M_ACC    = 4'd1,
        M_ZP     = 4'd2,
        M_ZPX    = 4'd3,
        M_ZPY    = 4'd4,
        M_ABS    = 4'd5,
        M_ABSX   = 4'd6,
        M_ABSY   = 4'd7,
        M_INDX   = 4'd8,
        M_INDY   = 4'd9,
        M_IMPL   = 4'd10,
        M_INDABS = 4'd11,
        M_REL    = 4'd12,
        M_RSV13  = 4'd13,
        M_RSV14  = 4'd14,
        M_RSV15  = 4'd15
    } mode_e;

    typedef enum logic [3:0] {
        C_READ_PX  = 4'd0,
        C_READ     = 4'd1,
        C_RMW      = 4'd2,
        C_STORE_A  = 4'd3,
        C_BREAK    = 4'd4,
        C_CALLRET  = 4'd5,
        C_JUMP     = 4'd6,
        C_PULL     = 4'd7,
        C_PUSH     = 4'd8,
        C_MISC9    = 4'd9,
        C_MISC10   = 4'd10,
        C_MISC11   = 4'd11,
        C_MISC12   = 4'd12,
        C_MISC13   = 4'd13,
        C_MISC14   = 4'd14,
        C_MISC15   = 4'd15
    } iclass_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PTR_LO  = 3'd1,
        S_PTR_HI  = 3'd2,
        S_VAL_REQ = 3'd3,
        S_VAL_CAP = 3'd4,
        S_DONE    = 3'd5
    } state_e;

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  mode_e               mode,
    input  logic [ADDR_W-1:0]   operand,
    input  logic [DATA_W-1:0]   idx_x,
    input  logic [DATA_W-1:0]   idx_y,
    output logic [ADDR_W-1:0]   direct_ea,
    output logic [ADDR_W-1:0]   ptr_lo_addr,
    output logic [ADDR_W-1:0]   ptr_hi_addr,
    output logic                abs_cross,
    output logic                needs_ptr,
    output logic                needs_val
);
    logic [DATA_W-1:0] zp_x, zp_y, zp_ptr, zp_ptr_n;
    logic [ADDR_W-1:0] abs_x, abs_y;

    always_comb begin
        zp_x     = operand[DATA_W-1:0] + idx_x;
        zp_y     = operand[DATA_W-1:0] + idx_y;
        zp_ptr   = zp_x;
        zp_ptr_n = zp_x + 1'b1;
        abs_x    = operand + {{DATA_W{1'b0}}, idx_x};
        abs_y    = operand + {{DATA_W{1'b0}}, idx_y};
    end

    always_comb begin
        direct_ea   = '0;
        ptr_lo_addr = '0;
        ptr_hi_addr = '0;
        abs_cross   = 1'b0;
        needs_ptr   = 1'b0;
        needs_val   = 1'b0;
        unique case (mode)
            M_ZP: begin
                direct_ea = {{DATA_W{1'b0}}, operand[DATA_W-1:0]};
                needs_val = 1'b1;
            end
            M_ZPX: begin
                direct_ea = {{DATA_W{1'b0}}, zp_x};
                needs_val = 1'b1;
            end
            M_ZPY: begin
                direct_ea = {{DATA_W{1'b0}}, zp_y};
                needs_val = 1'b1;
            end
            M_ABS: begin
                direct_ea = operand;
                needs_val = 1'b1;
            end
            M_ABSX: begin
                direct_ea = abs_x;
                abs_cross = abs_x[ADDR_W-1:DATA_W] != operand[ADDR_W-1:DATA_W];
                needs_val = 1'b1;
            end
            M_ABSY: begin
                direct_ea = abs_y;
                abs_cross = abs_y[ADDR_W-1:DATA_W] != operand[ADDR_W-1:DATA_W];
                needs_val = 1'b1;
            end
            M_INDX: begin
                ptr_lo_addr = {{DATA_W{1'b0}}, zp_ptr};
                ptr_hi_addr = {{DATA_W{1'b0}}, zp_ptr_n};
                needs_ptr   = 1'b1;
                needs_val   = 1'b1;
            end
            M_INDY: begin
                ptr_lo_addr = operand;
                ptr_hi_addr = operand + 1'b1;
                needs_ptr   = 1'b1;
                needs_val   = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ea_cycle_rom.sv
module ea_cycle_rom
    import ea_pkg::*;
#(
    parameter int CYC_W = 4,
    parameter int LEN_W = 2
) (
    input  mode_e             mode,
    input  iclass_e           iclass,
    output logic [CYC_W-1:0]  base_cycles,
    output logic [LEN_W-1:0]  len_bytes,
    output logic              penalty_ok
);
    always_comb begin
        unique case (mode)
            M_ABS, M_ABSX, M_ABSY: len_bytes = LEN_W'(3);
            M_ACC:                 len_bytes = LEN_W'(1);
            default:               len_bytes = LEN_W'(2);
        endcase
    end

    always_comb begin
        penalty_ok  = 1'b0;
        base_cycles = CYC_W'(2);
        unique case (iclass)
            C_READ_PX, C_READ: begin
                penalty_ok = (iclass == C_READ_PX) &&
                             (mode == M_ABSX || mode == M_ABSY || mode == M_INDY);
                unique case (mode)
                    M_ZP:                          base_cycles = CYC_W'(3);
                    M_ZPX, M_ABS, M_ABSX, M_ABSY:  base_cycles = CYC_W'(4);
                    M_INDX:                        base_cycles = CYC_W'(6);
                    M_INDY:                        base_cycles = CYC_W'(5);
                    default:                       base_cycles = CYC_W'(2);
                endcase
            end
            C_RMW: begin
                unique case (mode)
                    M_ZP:          base_cycles = CYC_W'(5);
                    M_ZPX, M_ABS:  base_cycles = CYC_W'(6);
                    M_ABSX:        base_cycles = CYC_W'(7);
                    default:       base_cycles = CYC_W'(2);
                endcase
            end
            C_STORE_A: begin
                unique case (mode)
                    M_ZP:            base_cycles = CYC_W'(3);
                    M_ZPX, M_ABS:    base_cycles = CYC_W'(4);
                    M_ABSX, M_ABSY:  base_cycles = CYC_W'(5);
                    M_INDX, M_INDY:  base_cycles = CYC_W'(6);
                    default:         base_cycles = CYC_W'(2);
                endcase
            end
            C_BREAK:   base_cycles = CYC_W'(7);
            C_CALLRET: base_cycles = CYC_W'(6);
            C_JUMP:    base_cycles = CYC_W'(5);
            C_PULL:    base_cycles = CYC_W'(4);
            C_PUSH:    base_cycles = CYC_W'(3);
            default:   base_cycles = CYC_W'(2);
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CYC_W  = 4,
    parameter int LEN_W  = 2,
    parameter int MODE_W = 4,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [DATA_W-1:0] acc,
    input  logic [MODE_W-1:0] iclass,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] value,
    output logic [LEN_W-1:0]  length,
    output logic [CYC_W-1:0]  cycles
);
    state_e st, st_nx;
    mode_e  mode_in, mode_q;

    logic [ADDR_W-1:0] direct_ea, ptr_lo_addr, ptr_hi_addr;
    logic              abs_cross, needs_ptr, needs_val;
    logic [CYC_W-1:0]  base_cycles;
    logic [LEN_W-1:0]  len_bytes;
    logic              penalty_ok;

    logic [ADDR_W-1:0] ea_q, ptr_lo_q, ptr_hi_q;
    logic [DATA_W-1:0] val_q, y_q, lo_q;
    logic [LEN_W-1:0]  len_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              pen_ok_q;

    logic [ADDR_W-1:0] ptr_base, ind_ea;
    logic              ind_cross;
    logic              accept;

    assign mode_in = mode_e'(mode);
    assign accept  = (st == S_IDLE) && start;

    ea_addr_gen #(.DATA_W(DATA_W)) u_addr (
        .mode        (mode_in),
        .operand     (operand),
        .idx_x       (idx_x),
        .idx_y       (idx_y),
        .direct_ea   (direct_ea),
        .ptr_lo_addr (ptr_lo_addr),
        .ptr_hi_addr (ptr_hi_addr),
        .abs_cross   (abs_cross),
        .needs_ptr   (needs_ptr),
        .needs_val   (needs_val)
    );

    ea_cycle_rom #(.CYC_W(CYC_W), .LEN_W(LEN_W)) u_cyc (
        .mode        (mode_in),
        .iclass      (iclass_e'(iclass)),
        .base_cycles (base_cycles),
        .len_bytes   (len_bytes),
        .penalty_ok  (penalty_ok)
    );

    // pointer assembled from the captured low byte and the high byte arriving now
    always_comb begin
        ptr_base  = {mem_rdata, lo_q};
        ind_ea    = (mode_q == M_INDY) ? ptr_base + {{DATA_W{1'b0}}, y_q} : ptr_base;
        ind_cross = (mode_q == M_INDY) &&
                    (ind_ea[ADDR_W-1:DATA_W] != ptr_base[ADDR_W-1:DATA_W]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (needs_ptr)      st_nx = S_PTR_LO;
                    else if (needs_val) st_nx = S_VAL_REQ;
                    else                st_nx = S_DONE;
                end
            end
            S_PTR_LO:  st_nx = S_PTR_HI;
            S_PTR_HI:  st_nx = S_VAL_REQ;
            S_VAL_REQ: st_nx = S_VAL_CAP;
            S_VAL_CAP: st_nx = S_DONE;
            S_DONE:    st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // outputs driven by the state
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        unique case (st)
            S_PTR_LO: begin
                mem_req  = 1'b1;
                mem_addr = ptr_lo_q;
            end
            S_PTR_HI: begin
                mem_req  = 1'b1;
                mem_addr = ptr_hi_q;
            end
            S_VAL_REQ: begin
                mem_req  = 1'b1;
                mem_addr = (mode_q == M_INDX || mode_q == M_INDY) ? ind_ea : ea_q;
            end
            default: begin
            end
        endcase
    end

    assign busy     = (st != S_IDLE);
    assign done     = (st == S_DONE);
    assign eff_addr = ea_q;
    assign value    = val_q;
    assign length   = len_q;
    assign cycles   = cyc_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= M_IMPL;
            ea_q     <= '0;
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
            val_q    <= '0;
            y_q      <= '0;
            lo_q     <= '0;
            len_q    <= '0;
            cyc_q    <= '0;
            pen_ok_q <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (accept) begin
                        mode_q   <= mode_in;
                        ea_q     <= direct_ea;
                        ptr_lo_q <= ptr_lo_addr;
                        ptr_hi_q <= ptr_hi_addr;
                        y_q      <= idx_y;
                        len_q    <= len_bytes;
                        pen_ok_q <= penalty_ok;
                        cyc_q    <= base_cycles + CYC_W'(penalty_ok && abs_cross);
                        if (mode_in == M_IMM)      val_q <= operand[DATA_W-1:0];
                        else if (mode_in == M_ACC) val_q <= acc;
                        else                       val_q <= '0;
                    end
                end
                S_PTR_HI:  lo_q <= mem_rdata;
                S_VAL_REQ: begin
                    ea_q <= mem_addr;
                    if (pen_ok_q && ind_cross) cyc_q <= cyc_q + 1'b1;
                end
                S_VAL_CAP: val_q <= mem_rdata;
                default: begin
                end
            endcase
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    acc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == M_ACC) |-> (length == LEN_W'(1)));

    // R5
    no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == M_IMM || mode_q == M_ACC || mode_q == M_IMPL ||
                  mode_q == M_INDABS || mode_q == M_REL)) |-> !mem_req);

    // R7
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CYC_W'(2) && cycles <= CYC_W'(8)));

    // R1
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY))
            |-> (eff_addr[ADDR_W-1:DATA_W] == '0));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(len_q));
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] operand = 16'd0;
    logic [7:0]  idx_x = 8'd0, idx_y = 8'd0, acc = 8'd0;
    logic [3:0]  iclass = 4'd0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic        busy, done;
    logic [15:0] eff_addr;
    logic [7:0]  value;
    logic [1:0]  length;
    logic [3:0]  cycles;

    int errors = 0;
    int checks = 0;
    int reads  = 0;

    always #2.5 clk = ~clk;

    ea_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
        .idx_x(idx_x), .idx_y(idx_y), .acc(acc), .iclass(iclass),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .eff_addr(eff_addr), .value(value),
        .length(length), .cycles(cycles)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memf(mem_addr);
            reads <= reads + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] m, input logic [15:0] op,
                          input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                          input logic [3:0] c, input logic [15:0] e_ea, input logic [7:0] e_val,
                          input int e_len, input int e_cyc, input int e_lat, input int e_rd);
        int lat;
        @(negedge clk);
        mode = m; operand = op; idx_x = x; idx_y = y; acc = a; iclass = c;
        reads = 0;
        start = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(req, "latency", lat, e_lat);
        chk(req, "eff_addr", eff_addr, e_ea);
        chk(req, "value", value, e_val);
        chk(req, "length", length, e_len);
        chk(req, "cycles", cycles, e_cyc);
        chk(req, "reads", reads, e_rd);
        @(negedge clk);
        chk("R12", "done one clock", done, 0);
    endtask

    task automatic t_reset();
        chk("R12", "reset done", done, 0);
        chk("R12", "reset busy", busy, 0);
        chk("R5", "reset mem_req", mem_req, 0);
    endtask

    task automatic t_zero_page();
        // R1
        run_op("R1", 4'd2, 16'hAB34, 8'h00, 8'h00, 8'h00, 4'd0, 16'h0034, memf(16'h0034), 2, 3, 3, 1);
        run_op("R1", 4'd3, 16'h12C0, 8'h50, 8'h00, 8'h00, 4'd0, 16'h0010, memf(16'h0010), 2, 4, 3, 1);
        run_op("R1", 4'd4, 16'h00FF, 8'h00, 8'h02, 8'h00, 4'd0, 16'h0001, memf(16'h0001), 2, 2, 3, 1);
    endtask

    task automatic t_absolute();
        // R2, R11
        run_op("R2", 4'd5, 16'h3456, 8'h00, 8'h00, 8'h00, 4'd0, 16'h3456, memf(16'h3456), 3, 4, 3, 1);
        run_op("R11", 4'd6, 16'h12F0, 8'h20, 8'h00, 8'h00, 4'd0, 16'h1310, memf(16'h1310), 3, 5, 3, 1);
        run_op("R11", 4'd6, 16'h12F0, 8'h20, 8'h00, 8'h00, 4'd1, 16'h1310, memf(16'h1310), 3, 4, 3, 1);
        run_op("R2", 4'd7, 16'h1200, 8'h00, 8'h10, 8'h00, 4'd0, 16'h1210, memf(16'h1210), 3, 4, 3, 1);
        run_op("R2", 4'd6, 16'hFFF0, 8'h20, 8'h00, 8'h00, 4'd0, 16'h0010, memf(16'h0010), 3, 5, 3, 1);
    endtask

    task automatic t_indirect();
        logic [15:0] p;
        // R3: pointer bytes at 0x00FF and 0x0000 (wrap in page zero)
        p = {memf(16'h0000), memf(16'h00FF)};
        run_op("R3", 4'd8, 16'h00F0, 8'h0F, 8'h00, 8'h00, 4'd0, p, memf(p), 2, 6, 5, 3);
        // R4 with page crossing
        p = {memf(16'h1235), memf(16'h1234)} + 16'h00A0;
        run_op("R4", 4'd9, 16'h1234, 8'h00, 8'hA0, 8'h00, 4'd0, p, memf(p), 2, 6, 5, 3);
        run_op("R11", 4'd9, 16'h1234, 8'h00, 8'hA0, 8'h00, 4'd1, p, memf(p), 2, 5, 5, 3);
        p = {memf(16'h1235), memf(16'h1234)} + 16'h0010;
        run_op("R4", 4'd9, 16'h1234, 8'h00, 8'h10, 8'h00, 4'd0, p, memf(p), 2, 5, 5, 3);
    endtask

    task automatic t_values();
        // R5
        run_op("R5", 4'd0, 16'h77C3, 8'h00, 8'h00, 8'h11, 4'd0, 16'h0000, 8'hC3, 2, 2, 1, 0);
        run_op("R6", 4'd1, 16'h1234, 8'h00, 8'h00, 8'h9E, 4'd2, 16'h0000, 8'h9E, 1, 2, 1, 0);
        run_op("R5", 4'd12, 16'h00FE, 8'h00, 8'h00, 8'h9E, 4'd9, 16'h0000, 8'h00, 2, 2, 1, 0);
    endtask

    task automatic t_cycles();
        // R8
        run_op("R8", 4'd2, 16'h0040, 8'h00, 8'h00, 8'h00, 4'd2, 16'h0040, memf(16'h0040), 2, 5, 3, 1);
        run_op("R8", 4'd6, 16'h12F0, 8'h20, 8'h00, 8'h00, 4'd2, 16'h1310, memf(16'h1310), 3, 7, 3, 1);
        // R9
        run_op("R9", 4'd7, 16'h12F0, 8'h00, 8'h20, 8'h00, 4'd3, 16'h1310, memf(16'h1310), 3, 5, 3, 1);
        run_op("R9", 4'd3, 16'h0010, 8'h05, 8'h00, 8'h00, 4'd3, 16'h0015, memf(16'h0015), 2, 4, 3, 1);
        // R10
        run_op("R10", 4'd10, 16'h0000, 8'h00, 8'h00, 8'h00, 4'd4, 16'h0000, 8'h00, 2, 7, 1, 0);
        run_op("R10", 4'd10, 16'h0000, 8'h00, 8'h00, 8'h00, 4'd5, 16'h0000, 8'h00, 2, 6, 1, 0);
        run_op("R10", 4'd11, 16'h4000, 8'h00, 8'h00, 8'h00, 4'd6, 16'h0000, 8'h00, 2, 5, 1, 0);
        run_op("R10", 4'd10, 16'h0000, 8'h00, 8'h00, 8'h00, 4'd7, 16'h0000, 8'h00, 2, 4, 1, 0);
        run_op("R10", 4'd10, 16'h0000, 8'h00, 8'h00, 8'h00, 4'd8, 16'h0000, 8'h00, 2, 3, 1, 0);
    endtask

    task automatic t_busy_ignore();
        int lat;
        // R13
        @(negedge clk);
        mode = 4'd5; operand = 16'h2345; iclass = 4'd0; idx_x = 0; idx_y = 0;
        reads = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        mode = 4'd0; operand = 16'h00AA; iclass = 4'd4;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R13", "latency", lat, 3);
        chk("R13", "eff_addr", eff_addr, 16'h2345);
        chk("R13", "value", value, memf(16'h2345));
        chk("R13", "cycles", cycles, 4);
        chk("R13", "reads", reads, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_zero_page();
                t_absolute();
                t_indirect();
                t_values();
                t_cycles();
                t_busy_ignore();
                repeat (4) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL R12 watchdog: actual=hung expected=finish");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule